// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block is the device-side read path of a synchronous DRAM. On each rising clock edge it decodes the four command pins. When it sees a read, it captures the column address and the burst settings. It then walks the beat addresses of the burst, in either sequential or interleaved order, toward a simple synchronous storage array. The words that come back are delayed so that the first one appears on the data output exactly the programmed CAS latency after the command. Each later beat follows one clock after the one before it.

A read may arrive while an earlier burst is still running. The remaining unissued beats of the earlier burst are then abandoned and the new burst restarts at full length from its own column. Beats of the earlier burst that were already fetched keep draining from the output pipeline. The new burst's first word takes over in the cycle its own latency expires, so the output stream has no gap. When no burst word is due, the valid strobe is low and the data output is driven to zero, so a bus consumer treats it as released. The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the block accepts commands from the third rising edge after release.

Top module: `sdram_rd_seq`

## Requirements
- R1: A read is taken only when, at a rising edge, cs_n=0, ras_n=1, cas_n=0 and we_n=1. Every other pin combination starts nothing, and dq_valid stays low.
- R2: In the cycle after the edge that took a read, arr_rd_en is high and arr_addr equals the column address sampled with that read.
- R3: mode_bl is sampled with each read and selects 1, 2, 4 or 8 beats for the codes 0, 1, 2 and 3. An uninterrupted burst issues exactly that many consecutive array reads, and then arr_rd_en falls.
- R4: With mode_interleave=0 sampled at the read, the low log2(BL) bits of beat i are the start address's low bits plus i, modulo BL. The upper bits stay equal to the start address's upper bits.
- R5: With mode_interleave=1 sampled at the read, beat i's address is the start address XOR i.
- R6: With mode_cl3=0 the latency is 2 clocks, and with mode_cl3=1 it is 3 clocks. Beat i of a read taken at edge k is on dq_out, with dq_valid high, in the cycle after edge k+CL+i. The array word is expected one cycle after its address. mode_cl3 is held steady while reads are in flight.
- R7: A read taken at edge m, with m at least one clock after the previous read, cancels that read's unissued beats. Its already-issued beats still appear through edge m+CL-1, and the new burst's full-length beats follow from edge m+CL.
- R8: In any cycle with no beat due, dq_valid is 0 and dq_out is all zeros.
- R9: While rst_n is low, arr_rd_en and dq_valid are 0 and dq_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write-enable pin |
| col_addr | input | COL_W | Start column of a read |
| mode_bl | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8) |
| mode_interleave | input | 1 | 1 selects interleaved order, 0 sequential |
| mode_cl3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| arr_rdata | input | DATA_W | Array word, valid one cycle after arr_addr |
| arr_addr | output | COL_W | Column address of the current beat |
| arr_rd_en | output | 1 | Array read strobe for arr_addr |
| dq_out | output | DATA_W | Read data, zero when not valid |
| dq_valid | output | 1 | High in cycles that carry a burst word |

## Verification
The case that matters is a read taken in the same cycle that the running burst would issue another beat, or its last beat. In that cycle, the cancellation of the old beats, the restart of the beat counter and the draining of fetched words all meet. The bench provokes this directly with back-to-back reads at both latencies. It also provokes it through random command streams that often place reads on consecutive edges, mixed with non-read pin patterns. Each read is projected into a per-cycle table of expected words, where a later read overwrites every slot from its own latency onward. Each cycle's dq_valid and dq_out are then compared against that table, so a drained old beat and a premature or missing new beat are both caught.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic [1:0] {
    BL_ONE   = 2'd0,
    BL_TWO   = 2'd1,
    BL_FOUR  = 2'd2,
    BL_EIGHT = 2'd3
  } bl_code_e;

  // Read: select asserted, column strobe asserted, row strobe and write idle.
  function automatic logic is_read(input logic cs_n, input logic ras_n,
                                   input logic cas_n, input logic we_n);
    return (!cs_n) && ras_n && (!cas_n) && we_n;
  endfunction

endpackage

// File: rtl/sdram_cmd_dec.sv
module sdram_cmd_dec (
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic rd_cmd
);
  import sdram_rd_pkg::*;

  // R1: only the read pattern produces a command
  always_comb begin
    rd_cmd = is_read(cs_n, ras_n, cas_n, we_n);
  end

endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen #(
  parameter int COL_W  = 9,
  parameter int MAX_BL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_cmd,
  input  logic [COL_W-1:0] col_in,
  input  logic [1:0]       bl_in,
  input  logic             il_in,
  output logic             issue,
  output logic [COL_W-1:0] addr
);
  import sdram_rd_pkg::*;

  localparam int CNT_W = $clog2(MAX_BL);

  logic             act_q, act_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  bl_code_e         blc_q, blc_d;
  logic             il_q, il_d;

  logic [CNT_W-1:0] last_beat;
  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] seq_sum;

  always_comb begin
    last_beat = CNT_W'((1 << blc_q) - 1);
    wrap_mask = COL_W'((1 << blc_q) - 1);
  end

  // next-state
  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    blc_d  = blc_q;
    il_d   = il_q;
    if (rd_cmd) begin
      act_d  = 1'b1;
      base_d = col_in;
      cnt_d  = '0;
      blc_d  = bl_code_e'(bl_in);
      il_d   = il_in;
    end else if (act_q) begin
      if (cnt_q == last_beat) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      blc_q  <= BL_ONE;
      il_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      blc_q  <= blc_d;
      il_q   <= il_d;
    end
  end

  // beat address
  always_comb begin
    seq_sum = base_q + COL_W'(cnt_q);
    if (il_q) begin
      addr = base_q ^ COL_W'(cnt_q);
    end else begin
      addr = (base_q & ~wrap_mask) | (seq_sum & wrap_mask);
    end
    issue = act_q;
  end

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> (issue && addr == $past(col_in)));

  assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !rd_cmd && cnt_q == last_beat) |=> !issue);

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !rd_cmd && !il_q && cnt_q != last_beat) |=>
      (issue && ((addr & ~wrap_mask) == ($past(addr) & ~wrap_mask)) &&
       ((addr & wrap_mask) == (($past(addr) + 1'b1) & wrap_mask))));

  assert_il_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !rd_cmd && il_q && cnt_q != last_beat) |=>
      (issue && ((addr ^ $past(addr)) == (COL_W'(cnt_q) ^ COL_W'(cnt_q - 1'b1)))));

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DATA_W = 16,
  parameter int MIN_CL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              cl_long,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int MAX_CL = MIN_CL + 1;
  localparam int DST    = MAX_CL - 1;

  logic [MAX_CL-1:0]           v_q, v_d;
  logic [DST-1:0][DATA_W-1:0]  d_q, d_d;

  // next-state: valid shifts every cycle, data stages load only when fed
  always_comb begin
    v_d    = {v_q[MAX_CL-2:0], issue};
    d_d    = d_q;
    if (v_q[0]) d_d[0] = arr_rdata;
    for (int j = 1; j < DST; j++) begin
      if (v_q[j]) d_d[j] = d_q[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      d_q <= '0;
    end else begin
      v_q <= v_d;
      d_q <= d_d;
    end
  end

  always_comb begin
    if (cl_long) begin
      out_valid = v_q[MAX_CL-1];
      out_data  = out_valid ? d_q[DST-1] : '0;
    end else begin
      out_valid = v_q[MIN_CL-1];
      out_data  = out_valid ? d_q[MIN_CL-2] : '0;
    end
  end

  assert_lat_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl_long && $past(issue, 2)) |-> out_valid);

  assert_lat_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_long && $past(issue, 3)) |-> out_valid);

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl_long && !$past(issue, 2)) |-> !out_valid);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq #(
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int MAX_BL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [1:0]        mode_bl,
  input  logic              mode_interleave,
  input  logic              mode_cl3,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [COL_W-1:0]  arr_addr,
  output logic              arr_rd_en,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_valid
);

  logic [1:0] rst_q;
  logic       rst_s_n;
  logic       rd_cmd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  sdram_cmd_dec u_dec (
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .rd_cmd (rd_cmd)
  );

  sdram_burst_gen #(.COL_W(COL_W), .MAX_BL(MAX_BL)) u_gen (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .rd_cmd (rd_cmd),
    .col_in (col_addr),
    .bl_in  (mode_bl),
    .il_in  (mode_interleave),
    .issue  (arr_rd_en),
    .addr   (arr_addr)
  );

  sdram_rd_pipe #(.DATA_W(DATA_W), .MIN_CL(2)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .issue     (arr_rd_en),
    .cl_long   (mode_cl3),
    .arr_rdata (arr_rdata),
    .out_valid (dq_valid),
    .out_data  (dq_out)
  );

endmodule

// File: tb/sdram_rd_seq_tb.sv
`timescale 1ns/1ps
module sdram_rd_seq_tb;
  localparam int COL_W  = 9;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, ras_n, cas_n, we_n;
  logic [COL_W-1:0]  col_addr;
  logic [1:0]        mode_bl;
  logic              mode_interleave, mode_cl3;
  logic [DATA_W-1:0] arr_rdata;
  logic [COL_W-1:0]  arr_addr;
  logic              arr_rd_en;
  logic [DATA_W-1:0] dq_out;
  logic              dq_valid;

  always #4 clk = ~clk;

  sdram_rd_seq #(.COL_W(COL_W), .DATA_W(DATA_W), .MAX_BL(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .col_addr(col_addr), .mode_bl(mode_bl),
    .mode_interleave(mode_interleave), .mode_cl3(mode_cl3),
    .arr_rdata(arr_rdata), .arr_addr(arr_addr), .arr_rd_en(arr_rd_en),
    .dq_out(dq_out), .dq_valid(dq_valid)
  );

  function automatic logic [DATA_W-1:0] pat(input logic [COL_W-1:0] a);
    return {a[3:0] ^ 4'h9, 3'b101, a};
  endfunction

  // array model: word valid one cycle after its address
  always @(posedge clk) if (arr_rd_en) arr_rdata <= pat(arr_addr);

  int edges = 0;
  always @(posedge clk) edges <= edges + 1;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R8";
  logic              ev [32];
  logic [DATA_W-1:0] ed [32];
  int                r2_edge = -1;
  logic [COL_W-1:0]  r2_col;

  function automatic logic [COL_W-1:0] beat_addr(input logic [COL_W-1:0] b,
      input logic [1:0] bl, input bit il, input int i);
    int n = 1 << bl;
    logic [COL_W-1:0] m = COL_W'(n - 1);
    if (il) return b ^ COL_W'(i);
    return (b & ~m) | ((b + COL_W'(i)) & m);
  endfunction

  task automatic sched(input int k, input logic [COL_W-1:0] b,
                       input logic [1:0] bl, input bit il);
    int cl = mode_cl3 ? 3 : 2;
    for (int j = 0; j < 8; j++) begin
      ev[(k + cl + j) % 32] = 1'b0;
      ed[(k + cl + j) % 32] = '0;
    end
    for (int i = 0; i < (1 << bl); i++) begin
      ev[(k + cl + i) % 32] = 1'b1;
      ed[(k + cl + i) % 32] = pat(beat_addr(b, bl, il, i));
    end
  endtask

  task automatic check_out();
    int s = edges % 32;
    checks++;
    if (dq_valid !== ev[s] || dq_out !== (ev[s] ? ed[s] : '0)) begin
      fails++;
      $display("FAIL %s edge %0d: valid=%0b data=%h expected valid=%0b data=%h",
               cur_req, edges, dq_valid, dq_out, ev[s], ev[s] ? ed[s] : '0);
    end
    ev[s] = 1'b0;
    ed[s] = '0;
    if (r2_edge == edges) begin
      checks++;
      if (arr_rd_en !== 1'b1 || arr_addr !== r2_col) begin
        fails++;
        $display("FAIL R2 edge %0d: en=%0b addr=%h expected en=1 addr=%h",
                 edges, arr_rd_en, arr_addr, r2_col);
      end
    end
  endtask

  // one clock: check the previous edge, then drive for the next edge
  task automatic cyc(input bit rd, input logic [COL_W-1:0] col,
                     input logic [1:0] bl, input bit il, input bit junk);
    @(negedge clk);
    check_out();
    if (rd) begin
      {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      col_addr = col; mode_bl = bl; mode_interleave = il;
      sched(edges + 1, col, bl, il);
      r2_edge = edges + 1;
      r2_col  = col;
    end else if (junk) begin
      logic [3:0] p;
      do p = 4'($urandom); while (p == 4'b0101);
      {cs_n, ras_n, cas_n, we_n} = p;
      col_addr = COL_W'($urandom);
      mode_bl = 2'($urandom);
      mode_interleave = 1'($urandom);
    end else begin
      {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 2'd0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) begin ev[i] = 1'b0; ed[i] = '0; end
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    col_addr = '0; mode_bl = 2'd0; mode_interleave = 1'b0; mode_cl3 = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (arr_rd_en !== 1'b0 || dq_valid !== 1'b0 || dq_out !== '0) begin
      fails++;
      $display("FAIL R9: en=%0b valid=%0b data=%h expected 0 0 0",
               arr_rd_en, dq_valid, dq_out);
    end
    rst_n = 1'b1;
    idle(4);

    // R4: sequential wrap, BL4 from 0x0D -> 0D 0E 0F 0C, CL2
    cur_req = "R4";
    cyc(1, 9'h00D, 2'd2, 0, 0);
    idle(10);
    // R5: interleaved BL8 from 0x105, CL3
    mode_cl3 = 1'b1;
    cur_req = "R5";
    cyc(1, 9'h105, 2'd3, 1, 0);
    idle(14);
    // R3: single-beat bursts back to back
    cur_req = "R3";
    cyc(1, 9'h033, 2'd0, 0, 0);
    cyc(1, 9'h034, 2'd0, 1, 0);
    idle(8);
    // R7: interrupt on the next edge, CL3 then CL2
    cur_req = "R7";
    cyc(1, 9'h020, 2'd2, 0, 0);
    cyc(1, 9'h040, 2'd2, 0, 0);
    idle(12);
    mode_cl3 = 1'b0;
    cyc(1, 9'h0A6, 2'd3, 0, 0);
    idle(2);
    cyc(1, 9'h1F1, 2'd1, 1, 0);
    idle(12);
    // R1: non-read pin patterns start nothing
    cur_req = "R1";
    for (int i = 0; i < 40; i++) cyc(0, '0, 2'd0, 0, 1);
    idle(8);

    // random mix, R6 R7 R3 R4 R5 R2 all exercised
    cur_req = "R6/R7";
    for (int r = 0; r < 6; r++) begin
      mode_cl3 = 1'($urandom);
      for (int i = 0; i < 400; i++) begin
        int sel = $urandom % 10;
        if (sel < 3)
          cyc(1, COL_W'($urandom), 2'($urandom), 1'($urandom), 0);
        else
          cyc(0, '0, 2'd0, 0, sel < 6);
      end
      idle(14);
    end
    cur_req = "R8";
    idle(10);
    finish_run();
  end

endmodule